// File: doc/BRIEF.md
# UART Register and FIFO Front End

This block sits between a 32-bit processor bus and the serial engines of a simple UART. Software sees six word-aligned registers: control, mode, baud generator, channel status, a data port and a baud divider. Bus writes to the data port queue bytes in a 16-entry transmit FIFO. Bus reads of the data port take bytes from a 16-entry receive FIFO. The mode word and the two baud values go straight out to the serial engines. This block does no bit timing and no framing of its own.

Bytes move to and from the serial engines over plain valid/ready byte ports. The transmit side offers a byte only while transmission is enabled and its FIFO holds data. The receive side accepts a byte only while reception is enabled and its FIFO has room. Each direction has a reset bit in the control register. The bit clears itself after one cycle, and while it is high it empties that direction's FIFO and sends the direction's engine back to idle. The status word reports whether the transmit FIFO is empty and, as a separate bit, whether the engine is still shifting a character out.

Top module: `uart_regs_fe`

## Requirements
- R1: The registers decode at byte offsets 0x00 control (9 bits), 0x04 mode (11 bits), 0x18 baud generator (16 bits), 0x2C status (12 bits), 0x30 data and 0x34 baud divider (8 bits). Register bits above these widths read as zero, and any other offset reads as zero. After reset, the baud generator holds 0x028B, the baud divider holds 0x0F, and control and mode hold zero.
- R2: Control bit 4 drives `tx_enable` and control bit 2 drives `rx_enable`.
- R3: Writing a 1 to control bit 1 (transmit reset) or control bit 0 (receive reset) raises `tx_flush` or `rx_flush` for exactly the following cycle. During that cycle the bit reads back as 1, and after it the bit reads 0.
- R4: A transmit reset empties the transmit FIFO and leaves the receive FIFO alone. A receive reset empties the receive FIFO and leaves the transmit FIFO alone. A data write made during the transmit-reset cycle is lost.
- R5: Writes to the data register queue their low byte in the transmit FIFO. `tx_valid` is high only when `tx_enable` is set and the FIFO is not empty. Bytes leave in first-in, first-out order, one per cycle in which `tx_valid` and `tx_ready` are both high.
- R6: The transmit FIFO holds 16 bytes. A data write while it is full is dropped.
- R7: `rx_ready` is high only when `rx_enable` is set, the receive FIFO has room and no receive reset is under way. A byte is stored when `rx_valid` and `rx_ready` are both high. The receive FIFO holds 16 bytes.
- R8: A read of the data register returns the oldest received byte in bits 7:0 and removes it from the FIFO. A read while the receive FIFO is empty returns zero and changes nothing.
- R9: The status bits are: bit 11 = `tx_busy` (engine shifting), bit 4 = TX FIFO full, bit 3 = TX FIFO empty, bit 1 = RX FIFO empty. All other status bits are zero.
- R10: A data write and a transmit hand-off in the same cycle both take effect. The FIFO depth is unchanged and byte order is kept.
- R11: `mode_cfg`, `baud_gen` and `baud_div` always show the current contents of the mode, baud generator and baud divider registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_data | output | 8 | Byte offered to the transmit engine |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Transmit engine takes the byte |
| tx_busy | input | 1 | Transmit engine is shifting a character |
| rx_data | input | 8 | Byte from the receive engine |
| rx_valid | input | 1 | Receive byte available |
| rx_ready | output | 1 | Receive FIFO accepts the byte |
| tx_enable | output | 1 | Transmit enable to the engine |
| rx_enable | output | 1 | Receive enable to the engine |
| tx_flush | output | 1 | One-cycle transmit reset to the engine |
| rx_flush | output | 1 | One-cycle receive reset to the engine |
| mode_cfg | output | 11 | Mode register contents |
| baud_gen | output | 16 | Baud generator register contents |
| baud_div | output | 8 | Baud divider register contents |

## Verification
Two actions can hit the transmit FIFO in the same cycle: a bus write to the data register adds a byte, and the engine hand-off removes one. The bench sets up this clash by raising `tx_ready` in the same cycle as the data write, while the FIFO already holds bytes. It passes only if all three bytes then come out in order, with nothing lost and nothing repeated. A second clash is a transmit reset against a write that is still queued. The bench judges that one by reading the status word and watching `tx_valid`, which must show an empty FIFO, while the receive FIFO keeps its byte.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int ADDR_W = 6;
  localparam int BUS_W  = 32;
  localparam int CTRL_W = 9;
  localparam int MODE_W = 11;
  localparam int BGEN_W = 16;
  localparam int STAT_W = 12;
  localparam int BDIV_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_BGEN = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_DATA = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_BDIV = 6'h34;

  localparam int CB_TXEN  = 4;
  localparam int CB_RXEN  = 2;
  localparam int CB_TXRST = 1;
  localparam int CB_RXRST = 0;

  localparam int SB_TXACT   = 11;
  localparam int SB_TXFULL  = 4;
  localparam int SB_TXEMPTY = 3;
  localparam int SB_RXEMPTY = 1;

  function automatic logic [STAT_W-1:0] pack_status(input logic act, input logic tfull,
                                                   input logic tempty, input logic rempty);
    logic [STAT_W-1:0] s;
    s = '0;
    s[SB_TXACT]   = act;
    s[SB_TXFULL]  = tfull;
    s[SB_TXEMPTY] = tempty;
    s[SB_RXEMPTY] = rempty;
    return s;
  endfunction
endpackage

// File: rtl/uart_fe_fifo.sv
module uart_fe_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/uart_fe_regs.sv
module uart_fe_regs
  import uart_fe_pkg::*;
#(
  parameter logic [BGEN_W-1:0] BGEN_RST = 16'h028B,
  parameter logic [BDIV_W-1:0] BDIV_RST = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [BGEN_W-1:0] bgen_q,
  output logic [BDIV_W-1:0] bdiv_q
);
  logic unused_wdata;
  assign unused_wdata = ^wdata[BUS_W-1:BGEN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      bgen_q <= BGEN_RST;
      bdiv_q <= BDIV_RST;
    end else begin
      if (wr_en && addr == OFS_CTRL) begin
        ctrl_q <= wdata[CTRL_W-1:0];
      end else begin
        ctrl_q[CB_TXRST] <= 1'b0;
        ctrl_q[CB_RXRST] <= 1'b0;
      end
      if (wr_en && addr == OFS_MODE) mode_q <= wdata[MODE_W-1:0];
      if (wr_en && addr == OFS_BGEN) bgen_q <= wdata[BGEN_W-1:0];
      if (wr_en && addr == OFS_BDIV) bdiv_q <= wdata[BDIV_W-1:0];
    end
  end
endmodule

// File: rtl/uart_regs_fe.sv
module uart_regs_fe
  import uart_fe_pkg::*;
#(
  parameter int                FIFO_DEPTH = 16,
  parameter int                BYTE_W     = 8,
  parameter logic [BGEN_W-1:0] BGEN_RST   = 16'h028B,
  parameter logic [BDIV_W-1:0] BDIV_RST   = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic              tx_busy,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic [MODE_W-1:0] mode_cfg,
  output logic [BGEN_W-1:0] baud_gen,
  output logic [BDIV_W-1:0] baud_div
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] rx_head;
  logic              tx_empty, tx_full, rx_empty, rx_full;

  // named internal events
  logic bus_wr, bus_rd, data_wr, data_rd;
  logic tx_push, tx_pop, rx_push, rx_pop;

  assign bus_wr  = bus_en && bus_we;
  assign bus_rd  = bus_en && !bus_we;
  assign data_wr = bus_wr && bus_addr == OFS_DATA;
  assign data_rd = bus_rd && bus_addr == OFS_DATA;

  uart_fe_regs #(.BGEN_RST(BGEN_RST), .BDIV_RST(BDIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .mode_q(mode_cfg), .bgen_q(baud_gen), .bdiv_q(baud_div)
  );

  assign tx_enable = ctrl_q[CB_TXEN];
  assign rx_enable = ctrl_q[CB_RXEN];
  assign tx_flush  = ctrl_q[CB_TXRST];
  assign rx_flush  = ctrl_q[CB_RXRST];

  assign tx_push  = data_wr && !tx_full && !tx_flush;
  assign tx_valid = tx_enable && !tx_empty && !tx_flush;
  assign tx_pop   = tx_valid && tx_ready;

  assign rx_ready = rx_enable && !rx_full && !rx_flush;
  assign rx_push  = rx_valid && rx_ready;
  assign rx_pop   = data_rd && !rx_empty && !rx_flush;

  uart_fe_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .pop(tx_pop),
    .wdata(bus_wdata[BYTE_W-1:0]), .head(tx_data), .empty(tx_empty), .full(tx_full)
  );

  uart_fe_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .pop(rx_pop),
    .wdata(rx_data), .head(rx_head), .empty(rx_empty), .full(rx_full)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL: bus_rdata = BUS_W'(ctrl_q);
        OFS_MODE: bus_rdata = BUS_W'(mode_cfg);
        OFS_BGEN: bus_rdata = BUS_W'(baud_gen);
        OFS_STAT: bus_rdata = BUS_W'(pack_status(tx_busy, tx_full, tx_empty, rx_empty));
        OFS_DATA: bus_rdata = rx_pop ? BUS_W'(rx_head) : '0;
        OFS_BDIV: bus_rdata = BUS_W'(baud_div);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regs_fe_chk.sv
module uart_regs_fe_chk
  import uart_fe_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              tx_valid,
  input logic              tx_enable,
  input logic              tx_flush,
  input logic              rx_ready,
  input logic              rx_enable,
  input logic              rx_flush,
  input logic              tx_empty,
  input logic              tx_full,
  input logic              rx_empty,
  input logic              tx_push,
  input logic              tx_pop
);
  logic ctrl_wr, data_wr, data_rd;
  logic unused_chk;
  assign unused_chk = ^bus_wdata[BUS_W-1:2];
  assign ctrl_wr = bus_en && bus_we && bus_addr == OFS_CTRL;
  assign data_wr = bus_en && bus_we && bus_addr == OFS_DATA;
  assign data_rd = bus_en && !bus_we && bus_addr == OFS_DATA;

  // R3
  tx_rst_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !(ctrl_wr && bus_wdata[CB_TXRST])) |=> !tx_flush);
  // R3
  rx_rst_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush && !(ctrl_wr && bus_wdata[CB_RXRST])) |=> !rx_flush);
  // R4
  tx_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_empty);
  // R5
  tx_offer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_enable && !tx_empty));
  // R6
  full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && data_wr && !tx_pop && !tx_flush) |=> tx_full);
  // R7
  rx_accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (rx_enable && !rx_flush));
  // R8
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && data_rd) |-> (bus_rdata == '0));
  // R9
  tx_level_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));
  // R10
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_pop && !tx_flush) |=> ($stable(tx_empty) && $stable(tx_full)));
endmodule

bind uart_regs_fe uart_regs_fe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
  .tx_enable(tx_enable), .tx_flush(tx_flush), .rx_ready(rx_ready),
  .rx_enable(rx_enable), .rx_flush(rx_flush), .tx_empty(tx_empty),
  .tx_full(tx_full), .rx_empty(rx_empty), .tx_push(tx_push), .tx_pop(tx_pop)
);

// File: tb/uart_regs_fe_tb.sv
module uart_regs_fe_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0, tx_busy = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready, tx_enable, rx_enable, tx_flush, rx_flush;
  logic [10:0] mode_cfg;
  logic [15:0] baud_gen;
  logic [7:0]  baud_div;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_regs_fe u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_busy(tx_busy), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .mode_cfg(mode_cfg),
    .baud_gen(baud_gen), .baud_div(baud_div)
  );

  localparam logic [5:0] A_CTRL = 6'h00, A_MODE = 6'h04, A_BGEN = 6'h18,
                         A_STAT = 6'h2C, A_DATA = 6'h30, A_BDIV = 6'h34;

  // status word restated from the bit list of R9
  function automatic logic [31:0] st(input bit act, input bit tf, input bit te, input bit re);
    return (32'(act) << 11) | (32'(tf) << 4) | (32'(te) << 3) | (32'(re) << 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    chk(req, d, exp);
  endtask

  task automatic engine_take(input string req, input logic [7:0] exp);
    chk(req, {31'd0, tx_valid}, 32'd1);
    chk(req, 32'(tx_data), 32'(exp));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic engine_send(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R9 reset status", 32'(st(0, 0, 1, 1)), 32'h00A);
    read_chk("R9 reset status", A_STAT, st(0, 0, 1, 1));
    read_chk("R1 reset ctrl", A_CTRL, 32'h0);
    chk("R1 reset bgen", 32'(baud_gen), 32'h028B);
    chk("R1 reset bdiv", 32'(baud_div), 32'h0F);
    chk("R2 reset enables", {30'd0, tx_enable, rx_enable}, 32'd0);
    chk("R5 reset tx_valid", {31'd0, tx_valid}, 32'd0);
  endtask

  task automatic t_registers();
    bus_write(A_MODE, 32'hFFFF_FFFF);
    bus_write(A_BGEN, 32'hFFFF_FFFF);
    bus_write(A_BDIV, 32'hFFFF_FFFF);
    bus_write(A_CTRL, 32'hFFFF_FFFC);
    read_chk("R1 mode width", A_MODE, 32'h7FF);
    read_chk("R1 bgen width", A_BGEN, 32'hFFFF);
    read_chk("R1 bdiv width", A_BDIV, 32'hFF);
    read_chk("R1 ctrl width", A_CTRL, 32'h1FC);
    read_chk("R1 unmapped offset", 6'h08, 32'h0);
    chk("R11 mode out", 32'(mode_cfg), 32'h7FF);
    chk("R11 bgen out", 32'(baud_gen), 32'hFFFF);
    chk("R11 bdiv out", 32'(baud_div), 32'hFF);
    chk("R2 both enabled", {30'd0, tx_enable, rx_enable}, 32'd3);
    bus_write(A_CTRL, 32'h0000_0004);
    chk("R2 rx only", {30'd0, tx_enable, rx_enable}, 32'd1);
    bus_write(A_MODE, 32'h0000_0123);
    chk("R11 mode follows", 32'(mode_cfg), 32'h123);
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_tx_order_and_overflow();
    for (int i = 0; i < 17; i++) bus_write(A_DATA, 32'h40 + 32'(i));
    chk("R5 gated by enable", {31'd0, tx_valid}, 32'd0);
    read_chk("R6 full status", A_STAT, st(0, 1, 0, 1));
    bus_write(A_CTRL, 32'h10);
    for (int i = 0; i < 16; i++) engine_take("R6 R5 fifo order", 8'h40 + 8'(i));
    chk("R6 17th write dropped", {31'd0, tx_valid}, 32'd0);
    read_chk("R9 tx empty again", A_STAT, st(0, 0, 1, 1));
  endtask

  task automatic t_push_pop_same_cycle();
    bus_write(A_DATA, 32'hA1);
    bus_write(A_DATA, 32'hA2);
    chk("R10 head before clash", 32'(tx_data), 32'hA1);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_DATA; bus_wdata = 32'hA3;
    tx_ready = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; tx_ready = 1'b0;
    engine_take("R10 second byte", 8'hA2);
    engine_take("R10 third byte", 8'hA3);
    chk("R10 fifo drained", {31'd0, tx_valid}, 32'd0);
  endtask

  task automatic t_rx_path();
    bus_write(A_CTRL, 32'h04);
    for (int i = 0; i < 16; i++) begin
      chk("R7 ready with room", {31'd0, rx_ready}, 32'd1);
      engine_send(8'h80 + 8'(i));
    end
    chk("R7 not ready when full", {31'd0, rx_ready}, 32'd0);
    engine_send(8'hEE);
    for (int i = 0; i < 16; i++) read_chk("R8 rx order", A_DATA, 32'h80 + 32'(i));
    read_chk("R8 empty read zero", A_DATA, 32'h0);
    read_chk("R8 still empty", A_STAT, st(0, 0, 1, 1));
  endtask

  task automatic t_direction_resets();
    engine_send(8'h55);
    bus_write(A_DATA, 32'h11);
    bus_write(A_DATA, 32'h22);
    bus_write(A_CTRL, 32'h06);
    chk("R3 tx_flush pulse", {30'd0, tx_flush, rx_flush}, 32'd2);
    read_chk("R3 txrst reads 1", A_CTRL, 32'h06);
    chk("R3 tx_flush cleared", {31'd0, tx_flush}, 32'd0);
    read_chk("R3 txrst reads 0", A_CTRL, 32'h04);
    read_chk("R4 tx emptied rx kept", A_STAT, st(0, 0, 1, 0));
    read_chk("R4 rx byte survives", A_DATA, 32'h55);
    engine_send(8'h66);
    bus_write(A_DATA, 32'h33);
    bus_write(A_CTRL, 32'h05);
    chk("R3 rx_flush pulse", {30'd0, tx_flush, rx_flush}, 32'd1);
    @(negedge clk);
    chk("R3 rx_flush cleared", {31'd0, rx_flush}, 32'd0);
    read_chk("R4 rx emptied tx kept", A_STAT, st(0, 0, 0, 1));
    read_chk("R4 rx read after reset", A_DATA, 32'h0);
    bus_write(A_CTRL, 32'h10);
    engine_take("R4 tx byte survives", 8'h33);
    bus_write(A_CTRL, 32'h12);
    bus_write(A_DATA, 32'h77);
    @(negedge clk);
    chk("R4 write in reset cycle lost", {31'd0, tx_valid}, 32'd0);
  endtask

  task automatic t_busy_flag();
    tx_busy = 1'b1;
    read_chk("R9 active bit", A_STAT, st(1, 0, 1, 1));
    tx_busy = 1'b0;
    read_chk("R9 active cleared", A_STAT, st(0, 0, 1, 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_registers();
    t_tx_order_and_overflow();
    t_push_pop_same_cycle();
    t_rx_path();
    t_direction_resets();
    t_busy_flag();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule